// File: doc/BRIEF.md
# Ring Run-State Synchronizer with Stop-Fault Back-Propagation

This block coordinates the run state of a small group of PWM generator channels, three by default, wired in a ring. Each channel holds a local run bit and a link bit. A channel with its link bit clear is a master, and its effective run signal is its own run bit. A channel with its link bit set is a slave, and it takes the effective run state of the channel behind it in the ring. Channel n follows channel (n+CHANNELS-1) mod CHANNELS, so channel 0 follows the last channel. The block resolves the whole ring in one step. A single write to a master's run bit therefore starts or stops every slave linked behind it on the same clock edge.

Fault inputs are qualified per channel by an enable bit and a 3-bit mode code. Only the stop mode (code 7) has an effect here. An enabled stop fault on any channel clears the run bit of the master that heads that channel's group, so the whole group halts together. Faults in any other mode, and faults that are not enabled, leave the run state alone. If every channel is linked there is no master: all outputs are held low and a configuration-error flag is raised. The flag stays up until a write clears some link bit.

Software reaches the per-channel fields through a synchronous write port with a channel index, and can read back any channel's run bit.

Top module: `rsync_ring`

## Requirements
- R1: After reset every run bit, link bit, fault-enable bit and mode field is 0, `run_out` is all zero, `cfg_err` is 0 and `rd_run` reads 0.
- R2: A write with `wr_en` high stores into channel `wr_idx` the fields of `wr_data`: bit 0 is the run bit, bit 1 the link bit, bit 2 the fault enable and bits 5:3 the fault mode. For a master (link 0), `run_out[n]` equals that channel's run bit from the clock edge that stores it.
- R3: For a slave (link 1), `run_out[n]` equals `run_out[(n+CHANNELS-1) mod CHANNELS]`. Channel 0 follows the last channel.
- R4: Setting a master's run bit raises `run_out` of the master and of every slave linked behind it on the same clock edge, with no delay per hop.
- R5: Clearing a master's run bit drops `run_out` of the master and of all slaves linked behind it on the same clock edge.
- R6: A `fault_in` pulse on a slave whose fault enable is 1 and whose mode is 7 clears the run bit of its group's master on the next clock edge. The whole group's `run_out` goes low on that edge. The master's run bit then stays 0 until software writes it to 1 again.
- R7: An enabled mode-7 fault on a master clears that master's own run bit on the next clock edge.
- R8: A `fault_in` pulse on a channel whose mode is not 7, or whose fault enable is 0, changes no run bit and no `run_out` bit.
- R9: While all link bits are 1, `run_out` is all zero and `cfg_err` is 1. A write that clears any link bit returns `cfg_err` to 0 on the same edge.
- R10: `rd_run` shows the stored run bit of channel `rd_idx`. It reads 0 for an index of CHANNELS or above, and writes to such an index change nothing.
- R11: When a stop fault and a software write hit the same master's run bit in one cycle, the fault wins and the run bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the channel fields |
| wr_idx | input | IDX_W (2) | Channel written |
| wr_data | input | CTL_W (6) | {mode[2:0], fault enable, link, run} |
| rd_idx | input | IDX_W (2) | Channel whose run bit is read back |
| rd_run | output | 1 | Stored run bit of channel `rd_idx` |
| fault_in | input | CHANNELS (3) | Raw fault pulses, one per channel, synchronous to `clk` |
| run_out | output | CHANNELS (3) | Registered effective run signal per channel |
| cfg_err | output | 1 | High while every channel is linked |

## Verification
The assertions assume that `fault_in`, `wr_en`, `wr_idx` and `wr_data` are synchronous to `clk` and settled before each rising edge. They assume nothing about how long a fault lasts, since any single sampled cycle counts as an event. The stop-fault and no-change properties are written only for cycles without a write, because a write may legally relink or restart a channel in the same cycle. Fault-against-write priority is therefore checked by a directed case instead. The bench changes every input on the falling edge and samples outputs on the following falling edge. This keeps every stimulus cycle clean and unambiguous with respect to the rising edge that captures it.

// File: rtl/rsync_pkg.sv
`timescale 1ns/1ps
package rsync_pkg;

   // Field positions inside the write word
   localparam int unsigned CTL_RUN      = 0;
   localparam int unsigned CTL_LINK     = 1;
   localparam int unsigned CTL_FEN      = 2;
   localparam int unsigned CTL_MODE_LSB = 3;

   // Channel reached after stepping back `hops` positions around a ring of `cnt`
   function automatic int unsigned ring_back(input int unsigned chan,
                                             input int unsigned hops,
                                             input int unsigned cnt);
      return (chan + cnt - (hops % cnt)) % cnt;
   endfunction

endpackage

// File: rtl/rsync_chain_resolve.sv
`timescale 1ns/1ps
// Finds, for each channel, the nearest unlinked channel behind it in the ring.
module rsync_chain_resolve #(
   parameter int CH = 3,
   parameter int IW = 2
) (
   input  logic [CH-1:0] link,
   output logic [IW-1:0] mst_idx [CH],
   output logic [CH-1:0] mst_ok
);
   import rsync_pkg::*;

   for (genvar n = 0; n < CH; n++) begin : g_walk
      logic found;
      int unsigned sel;
      always_comb begin
         found = 1'b0;
         sel   = 0;
         for (int k = 0; k < CH; k++) begin
            if (!found && !link[ring_back(n, k, CH)]) begin
               found = 1'b1;
               sel   = ring_back(n, k, CH);
            end
         end
      end
      assign mst_ok[n]  = found;
      assign mst_idx[n] = IW'(sel);
   end

endmodule

// File: rtl/rsync_fault_route.sv
`timescale 1ns/1ps
// Turns qualified stop faults into run-bit clears aimed at each group's master.
module rsync_fault_route #(
   parameter int CH   = 3,
   parameter int IW   = 2,
   parameter int MW   = 3,
   parameter int STOP = 7
) (
   input  logic [CH-1:0] fault_in,
   input  logic [CH-1:0] fen,
   input  logic [MW-1:0] mode [CH],
   input  logic [IW-1:0] mst_idx [CH],
   input  logic [CH-1:0] mst_ok,
   output logic [CH-1:0] clr
);
   logic [CH-1:0] stop_hit;

   for (genvar c = 0; c < CH; c++) begin : g_qual
      assign stop_hit[c] = fault_in[c] & fen[c] & (mode[c] == MW'(STOP));
   end

   for (genvar t = 0; t < CH; t++) begin : g_target
      always_comb begin
         clr[t] = 1'b0;
         for (int c = 0; c < CH; c++) begin
            if (stop_hit[c] && mst_ok[c] && (mst_idx[c] == IW'(t)))
               clr[t] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rsync_ctrl_regs.sv
`timescale 1ns/1ps
// Per-channel field storage with next-state outputs.
module rsync_ctrl_regs #(
   parameter int CH = 3,
   parameter int IW = 2,
   parameter int MW = 3,
   parameter int CW = MW + 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [CW-1:0] wr_data,
   input  logic [CH-1:0] clr,
   output logic [CH-1:0] run_q,
   output logic [CH-1:0] link_q,
   output logic [CH-1:0] fen_q,
   output logic [MW-1:0] mode_q [CH],
   output logic [CH-1:0] run_d,
   output logic [CH-1:0] link_d
);
   import rsync_pkg::*;

   for (genvar n = 0; n < CH; n++) begin : g_chan
      logic          hit;
      logic          run_r, link_r, fen_r;
      logic [MW-1:0] mode_r;

      assign hit       = wr_en && (wr_idx == IW'(n));
      assign run_d[n]  = clr[n] ? 1'b0 : (hit ? wr_data[CTL_RUN] : run_r);
      assign link_d[n] = hit ? wr_data[CTL_LINK] : link_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_r  <= 1'b0;
            link_r <= 1'b0;
            fen_r  <= 1'b0;
            mode_r <= '0;
         end else begin
            run_r  <= run_d[n];
            link_r <= link_d[n];
            if (hit) begin
               fen_r  <= wr_data[CTL_FEN];
               mode_r <= wr_data[CTL_MODE_LSB +: MW];
            end
         end
      end

      assign run_q[n]  = run_r;
      assign link_q[n] = link_r;
      assign fen_q[n]  = fen_r;
      assign mode_q[n] = mode_r;
   end

endmodule

// File: rtl/rsync_ring.sv
`timescale 1ns/1ps
module rsync_ring #(
   parameter int CHANNELS  = 3,
   parameter int MODE_W    = 3,
   parameter int STOP_MODE = 7,
   parameter int IDX_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
   parameter int CTL_W     = MODE_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [CTL_W-1:0]    wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic                rd_run,
   input  logic [CHANNELS-1:0] fault_in,
   output logic [CHANNELS-1:0] run_out,
   output logic                cfg_err
);

   // Elaboration-time parameter checks
   if (CHANNELS < 2) begin : g_bad_ch
      $error("rsync_ring: CHANNELS must be at least 2");
   end
   if (MODE_W < 1 || STOP_MODE < 0 || STOP_MODE >= (1 << MODE_W)) begin : g_bad_mode
      $error("rsync_ring: STOP_MODE does not fit in MODE_W bits");
   end
   if ((1 << IDX_W) < CHANNELS) begin : g_bad_idx
      $error("rsync_ring: IDX_W too narrow for CHANNELS");
   end
   if (CTL_W != MODE_W + 3) begin : g_bad_ctl
      $error("rsync_ring: CTL_W must equal MODE_W + 3");
   end

   logic [CHANNELS-1:0] run_q, link_q, fen_q, run_d, link_d, clr;
   logic [MODE_W-1:0]   mode_q [CHANNELS];
   logic [IDX_W-1:0]    mst_idx_q [CHANNELS];
   logic [IDX_W-1:0]    mst_idx_d [CHANNELS];
   logic [CHANNELS-1:0] mst_ok_q, mst_ok_d, eff_d;
   logic [CHANNELS-1:0] run_out_q;
   logic                cfg_err_q;

   rsync_ctrl_regs #(.CH(CHANNELS), .IW(IDX_W), .MW(MODE_W), .CW(CTL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .clr(clr), .run_q(run_q), .link_q(link_q), .fen_q(fen_q), .mode_q(mode_q),
      .run_d(run_d), .link_d(link_d)
   );

   // Group heads under the present linkage: used to aim faults
   rsync_chain_resolve #(.CH(CHANNELS), .IW(IDX_W)) u_res_now (
      .link(link_q), .mst_idx(mst_idx_q), .mst_ok(mst_ok_q)
   );

   rsync_fault_route #(.CH(CHANNELS), .IW(IDX_W), .MW(MODE_W), .STOP(STOP_MODE)) u_route (
      .fault_in(fault_in), .fen(fen_q), .mode(mode_q),
      .mst_idx(mst_idx_q), .mst_ok(mst_ok_q), .clr(clr)
   );

   // Group heads under the linkage being stored: registered outputs carry no hop lag
   rsync_chain_resolve #(.CH(CHANNELS), .IW(IDX_W)) u_res_next (
      .link(link_d), .mst_idx(mst_idx_d), .mst_ok(mst_ok_d)
   );

   for (genvar n = 0; n < CHANNELS; n++) begin : g_eff
      assign eff_d[n] = mst_ok_d[n] & run_d[mst_idx_d[n]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_out_q <= '0;
         cfg_err_q <= 1'b0;
      end else begin
         run_out_q <= eff_d;
         cfg_err_q <= ~|mst_ok_d;
      end
   end

   assign run_out = run_out_q;
   assign cfg_err = cfg_err_q;

   always_comb begin
      rd_run = 1'b0;
      for (int n = 0; n < CHANNELS; n++) begin
         if (rd_idx == IDX_W'(n)) rd_run = run_q[n];
      end
   end

endmodule

// File: rtl/rsync_ring_chk.sv
`timescale 1ns/1ps
module rsync_ring_chk #(
   parameter int CH   = 3,
   parameter int MW   = 3,
   parameter int STOP = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [CH-1:0] fault_in,
   input logic [CH-1:0] run_q,
   input logic [CH-1:0] link_q,
   input logic [CH-1:0] fen_q,
   input logic [MW-1:0] mode_q [CH],
   input logic [CH-1:0] run_out,
   input logic          cfg_err
);
   import rsync_pkg::*;

   logic [CH-1:0] stop_ev;
   for (genvar n = 0; n < CH; n++) begin : g_ev
      assign stop_ev[n] = fault_in[n] && fen_q[n] && (mode_q[n] == MW'(STOP));
   end

   // R9
   cfg_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (run_out == '0));

   // R9
   cfg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&link_q) == cfg_err);

   // R8
   quiet_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && stop_ev == '0) |=> $stable(run_out));

   for (genvar n = 0; n < CH; n++) begin : g_ch
      localparam int unsigned PREV = ring_back(n, 1, CH);

      // R2
      master_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !link_q[n] |-> (run_out[n] == run_q[n]));

      // R3
      slave_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         link_q[n] |-> (run_out[n] == run_out[PREV]));

      // R6
      stop_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stop_ev[n] && !wr_en) |=> !run_out[n]);
   end

endmodule

bind rsync_ring rsync_ring_chk #(.CH(CHANNELS), .MW(MODE_W), .STOP(STOP_MODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fault_in(fault_in),
   .run_q(run_q), .link_q(link_q), .fen_q(fen_q), .mode_q(mode_q),
   .run_out(run_out), .cfg_err(cfg_err)
);

// File: tb/rsync_ring_bench.sv
`timescale 1ns/1ps
module rsync_ring_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_idx = '0;
   logic [5:0] wr_data = '0;
   logic [1:0] rd_idx = '0;
   logic       rd_run;
   logic [2:0] fault_in = '0;
   logic [2:0] run_out;
   logic       cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rsync_ring u_rsync_ring (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_run(rd_run), .fault_in(fault_in),
      .run_out(run_out), .cfg_err(cfg_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Write one channel; returns at the falling edge after the capturing edge
   task automatic put(input logic [1:0] idx, input logic run, input logic link,
                      input logic fen, input logic [2:0] mode);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = {mode, fen, link, run};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [2:0] mask);
      @(negedge clk);
      fault_in = mask;
      @(negedge clk);
      fault_in = '0;
   endtask

   task automatic read_run(input logic [1:0] idx, output logic val);
      rd_idx = idx;
      #1;
      val = rd_run;
   endtask

   task automatic t_reset();
      logic v;
      check("R1 run_out", run_out, 3'b000);
      check("R1 cfg_err", cfg_err, 1'b0);
      for (int i = 0; i < 3; i++) begin
         read_run(2'(i), v);
         check("R1 rd_run", v, 1'b0);
      end
   endtask

   task automatic t_master();
      put(2'd0, 1, 0, 0, 3'd0);
      put(2'd1, 0, 0, 0, 3'd0);
      put(2'd2, 0, 0, 0, 3'd0);
      check("R2 master on", run_out, 3'b001);
      put(2'd0, 0, 0, 0, 3'd0);
      check("R2 master off", run_out, 3'b000);
   endtask

   task automatic t_ring_wrap();
      put(2'd2, 1, 0, 0, 3'd0);
      put(2'd0, 0, 1, 0, 3'd0);
      check("R3 ch0 follows ch2", run_out, 3'b101);
      put(2'd2, 0, 0, 0, 3'd0);
      check("R3 ch0 follows ch2 low", run_out, 3'b000);
      put(2'd0, 0, 0, 0, 3'd0);
   endtask

   task automatic t_group();
      put(2'd0, 0, 0, 0, 3'd0);
      put(2'd1, 0, 1, 0, 3'd0);
      put(2'd2, 0, 1, 1, 3'd7);
      check("R4 idle group", run_out, 3'b000);
      put(2'd0, 1, 0, 0, 3'd0);
      check("R4 group start same edge", run_out, 3'b111);
      put(2'd0, 0, 0, 0, 3'd0);
      check("R5 group stop same edge", run_out, 3'b000);
   endtask

   task automatic t_slave_fault();
      logic v;
      put(2'd0, 1, 0, 0, 3'd0);
      check("R6 group running", run_out, 3'b111);
      pulse(3'b100);
      check("R6 slave stop fault halts group", run_out, 3'b000);
      read_run(2'd0, v);
      check("R6 master run bit cleared", v, 1'b0);
      repeat (3) @(negedge clk);
      check("R6 stays stopped", run_out, 3'b000);
      put(2'd0, 1, 0, 0, 3'd0);
      check("R6 restart by write", run_out, 3'b111);
   endtask

   task automatic t_other_faults();
      put(2'd2, 0, 1, 1, 3'd3);
      pulse(3'b100);
      check("R8 non-stop mode ignored", run_out, 3'b111);
      put(2'd2, 0, 1, 0, 3'd7);
      pulse(3'b100);
      check("R8 disabled fault ignored", run_out, 3'b111);
      put(2'd1, 0, 1, 1, 3'd6);
      pulse(3'b010);
      check("R8 mode 6 ignored", run_out, 3'b111);
   endtask

   task automatic t_master_fault();
      logic v;
      put(2'd0, 1, 0, 1, 3'd7);
      pulse(3'b001);
      check("R7 master stop fault", run_out, 3'b000);
      read_run(2'd0, v);
      check("R7 master run bit", v, 1'b0);
   endtask

   task automatic t_collision();
      logic v;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'd0; wr_data = {3'd7, 1'b1, 1'b0, 1'b1};
      fault_in = 3'b001;
      @(negedge clk);
      wr_en = 1'b0; fault_in = '0;
      check("R11 fault beats write", run_out, 3'b000);
      read_run(2'd0, v);
      check("R11 run bit", v, 1'b0);
   endtask

   task automatic t_cfg_err();
      put(2'd0, 1, 0, 0, 3'd0);
      check("R9 before all linked", run_out, 3'b111);
      put(2'd0, 1, 1, 0, 3'd0);
      check("R9 all linked outputs", run_out, 3'b000);
      check("R9 flag set", cfg_err, 1'b1);
      repeat (2) @(negedge clk);
      check("R9 flag sticky", cfg_err, 1'b1);
      put(2'd1, 0, 0, 0, 3'd0);
      check("R9 flag cleared", cfg_err, 1'b0);
      check("R9 new master idle", run_out, 3'b000);
      put(2'd1, 1, 0, 0, 3'd0);
      check("R4 start from ch1", run_out, 3'b111);
   endtask

   task automatic t_readback();
      logic v;
      read_run(2'd1, v);
      check("R10 read ch1", v, 1'b1);
      read_run(2'd0, v);
      check("R10 read ch0", v, 1'b1);
      read_run(2'd2, v);
      check("R10 read ch2", v, 1'b0);
      put(2'd3, 0, 0, 0, 3'd0);
      check("R10 bad index write ignored", run_out, 3'b111);
      read_run(2'd3, v);
      check("R10 bad index read", v, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_master();
      t_ring_wrap();
      t_group();
      t_slave_fault();
      t_other_faults();
      t_master_fault();
      t_collision();
      t_cfg_err();
      t_readback();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule